// File: doc/BRIEF.md
# MESIF Cache Line State Controller

This block keeps the coherence state of every line in a small private cache bank. Each line is in one of five states: Invalid, Shared, Exclusive, Modified or Forward. Forward marks the one clean sharer that answers read snoops from other caches. The core issues read, write, evict and clean requests against a line index. The block completes hits and silent upgrades itself. For a miss, an upgrade or a dirty write-back, it sends a message to the interconnect and waits for the matching response. Incoming snoops change line state right away and get an answer one cycle later. The answer says whether a valid copy was held and whether this cache supplies the data.

Each line may have only one outstanding interconnect transaction. A further core request to a line with a pending transaction stalls. Requests to other lines are still accepted. Snoops never stall. A snoop may land on a line whose transaction is still in flight, and the response is then resolved against the state the snoop left behind.

Top module: `mesif_ctrl`

## Requirements
- R1: After reset every line is Invalid and nothing is pending. done_valid_o, msg_valid_o and snp_rsp_valid_o are low, and req_ready_o is high for an idle request.
- R2: A read (req_op_i=0) to an Invalid line sends a read message (msg_type_o=0). The matching response completes it with state Exclusive (done_state_o=2) when rsp_shared_i is 0, and Forward (4) when it is 1.
- R3: A read to a Shared (1), Exclusive, Modified (3) or Forward line sends no message. It completes in the cycle after acceptance, and the state is unchanged.
- R4: A write (req_op_i=1) to an Exclusive or Modified line sends no message and completes as Modified.
- R5: A write to a Shared, Forward or Invalid line sends a read-for-ownership message (msg_type_o=1). Its response completes the line as Modified.
- R6: An evict (req_op_i=2) of a Modified line sends a write-back (msg_type_o=2), and its response leaves the line Invalid (0). An evict in any other state completes at once as Invalid with no message.
- R7: A clean (req_op_i=3) of a Modified line sends a write-back, and its response moves the line to Exclusive only if it is still Modified at that point. A clean in any other state sends no message and leaves the state unchanged.
- R8: A request stalls (req_ready_o low) when its line has a pending transaction, when a response arrives in the same cycle, or when it needs a message and msg_ready_i is low. Requests to other lines proceed.
- R9: A read snoop (snp_type_i=0) to a Modified, Exclusive or Forward line returns hit and data and leaves the line Shared. A read snoop to a Shared line returns hit without data. A read snoop to an Invalid line returns neither. The answer appears in the cycle after the snoop.
- R10: An invalidate snoop (snp_type_i=1) moves any line to Invalid. It returns hit for a valid line, and data only from a Modified line.
- R11: A snoop to the same line as a core request in the same cycle takes priority, and the core request stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Core request valid |
| req_op_i | input | 2 | 0 read, 1 write, 2 evict, 3 clean |
| req_line_i | input | LINE_W | Target line index |
| req_ready_o | output | 1 | Request accepted this cycle |
| done_valid_o | output | 1 | A request completed |
| done_line_o | output | LINE_W | Line of completed request |
| done_state_o | output | 3 | Resulting state: 0 I, 1 S, 2 E, 3 M, 4 F |
| msg_valid_o | output | 1 | Outbound message valid |
| msg_type_o | output | 2 | 0 read, 1 read-for-ownership, 2 write-back |
| msg_line_o | output | LINE_W | Line of outbound message |
| msg_ready_i | input | 1 | Interconnect takes the message |
| rsp_valid_i | input | 1 | Interconnect response valid |
| rsp_line_i | input | LINE_W | Line the response belongs to |
| rsp_shared_i | input | 1 | Another cache still holds the line |
| snp_valid_i | input | 1 | Snoop valid |
| snp_type_i | input | 1 | 0 read, 1 invalidate |
| snp_line_i | input | LINE_W | Snooped line |
| snp_rsp_valid_o | output | 1 | Snoop answer valid |
| snp_hit_o | output | 1 | A valid copy was held |
| snp_data_o | output | 1 | This cache supplies the data |

## Verification
The hardest case is a read snoop that reaches a Modified line while a clean write-back for that line is still pending. The snoop demotes the line to Shared before the response returns, so the response must not promote it to Exclusive. The bench writes a line to Modified and starts a clean. It injects the read snoop between the message and the response, then checks the state reported on completion and on a later read hit. Same-cycle contention is covered too: a snoop and a request on one line, a response together with a request, and back-pressure on the message port.

// File: rtl/mesif_pkg.sv
package mesif_pkg;

  typedef enum logic [2:0] {
    ST_I = 3'd0,
    ST_S = 3'd1,
    ST_E = 3'd2,
    ST_M = 3'd3,
    ST_F = 3'd4
  } line_st_e;

  typedef enum logic [1:0] {
    OP_RD    = 2'd0,
    OP_WR    = 2'd1,
    OP_EVICT = 2'd2,
    OP_CLEAN = 2'd3
  } req_op_e;

  typedef enum logic [1:0] {
    MSG_RD  = 2'd0,
    MSG_RFO = 2'd1,
    MSG_WB  = 2'd2
  } msg_type_e;

  // state after the interconnect answers a pending transaction
  function automatic line_st_e resolve_rsp(req_op_e kind, line_st_e cur, logic shared);
    line_st_e r;
    unique case (kind)
      OP_RD:    r = shared ? ST_F : ST_E;
      OP_WR:    r = ST_M;
      OP_EVICT: r = ST_I;
      default:  r = (cur == ST_M) ? ST_E : cur;
    endcase
    return r;
  endfunction

  // snoop, then silent core update, then response: later stages win
  function automatic line_st_e line_next(
    line_st_e cur,
    logic     snp_hit, line_st_e snp_st,
    logic     req_hit, line_st_e req_st,
    logic     rsp_hit, req_op_e  kind, logic shared
  );
    line_st_e s;
    s = snp_hit ? snp_st : cur;
    if (req_hit) s = req_st;
    if (rsp_hit) s = resolve_rsp(kind, s, shared);
    return s;
  endfunction

endpackage

// File: rtl/mesif_req_ctrl.sv
module mesif_req_ctrl
  import mesif_pkg::*;
(
  input  req_op_e   op_i,
  input  line_st_e  cur_i,
  output logic      need_msg_o,
  output msg_type_e msg_type_o,
  output line_st_e  hit_st_o
);

  always_comb begin
    need_msg_o = 1'b0;
    msg_type_o = MSG_RD;
    hit_st_o   = cur_i;
    unique case (op_i)
      OP_RD: begin
        if (cur_i == ST_I) begin
          need_msg_o = 1'b1;
          msg_type_o = MSG_RD;
        end
      end
      OP_WR: begin
        if (cur_i == ST_E || cur_i == ST_M) begin
          hit_st_o = ST_M;
        end else begin
          need_msg_o = 1'b1;
          msg_type_o = MSG_RFO;
        end
      end
      OP_EVICT: begin
        if (cur_i == ST_M) begin
          need_msg_o = 1'b1;
          msg_type_o = MSG_WB;
        end else begin
          hit_st_o = ST_I;
        end
      end
      default: begin
        if (cur_i == ST_M) begin
          need_msg_o = 1'b1;
          msg_type_o = MSG_WB;
        end
      end
    endcase
  end

endmodule

// File: rtl/mesif_snoop_unit.sv
module mesif_snoop_unit
  import mesif_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     snp_valid_i,
  input  logic     snp_type_i,
  input  line_st_e cur_i,
  output line_st_e nxt_o,
  output logic     rsp_valid_o,
  output logic     hit_o,
  output logic     data_o
);

  logic hit_d, data_d;

  always_comb begin
    hit_d  = (cur_i != ST_I);
    data_d = 1'b0;
    nxt_o  = cur_i;
    if (snp_type_i) begin
      nxt_o  = ST_I;
      data_d = (cur_i == ST_M);
    end else begin
      unique case (cur_i)
        ST_M, ST_E, ST_F: begin
          nxt_o  = ST_S;
          data_d = 1'b1;
        end
        default: nxt_o = cur_i;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      hit_o       <= 1'b0;
      data_o      <= 1'b0;
    end else begin
      rsp_valid_o <= snp_valid_i;
      hit_o       <= snp_valid_i & hit_d;
      data_o      <= snp_valid_i & data_d;
    end
  end

endmodule

// File: rtl/mesif_line_bank.sv
module mesif_line_bank
  import mesif_pkg::*;
#(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned LINE_W    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              snp_en_i,
  input  logic [LINE_W-1:0] snp_line_i,
  input  line_st_e          snp_st_i,
  input  logic              req_en_i,
  input  logic [LINE_W-1:0] req_line_i,
  input  logic              req_pend_i,
  input  line_st_e          req_st_i,
  input  req_op_e           req_op_i,
  input  logic              rsp_en_i,
  input  logic [LINE_W-1:0] rsp_line_i,
  input  logic              rsp_shared_i,
  output line_st_e          st_o   [NUM_LINES],
  output logic [NUM_LINES-1:0] pend_o,
  output logic              rsp_fire_o,
  output line_st_e          rsp_st_o
);

  line_st_e st_q   [NUM_LINES];
  line_st_e st_d   [NUM_LINES];
  req_op_e  kind_q [NUM_LINES];
  logic [NUM_LINES-1:0] pend_q, rsp_hit;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic snp_sel, req_sel, rsp_sel;
    assign snp_sel    = snp_en_i && (snp_line_i == LINE_W'(i));
    assign req_sel    = req_en_i && (req_line_i == LINE_W'(i));
    assign rsp_sel    = rsp_en_i && (rsp_line_i == LINE_W'(i));
    assign rsp_hit[i] = rsp_sel && pend_q[i];
    assign st_d[i]    = line_next(st_q[i], snp_sel, snp_st_i,
                                  req_sel && !req_pend_i, req_st_i,
                                  rsp_hit[i], kind_q[i], rsp_shared_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q[i]   <= ST_I;
        pend_q[i] <= 1'b0;
        kind_q[i] <= OP_RD;
      end else begin
        st_q[i] <= st_d[i];
        if (rsp_hit[i]) begin
          pend_q[i] <= 1'b0;
        end else if (req_sel && req_pend_i) begin
          pend_q[i] <= 1'b1;
          kind_q[i] <= req_op_i;
        end
      end
    end

    assign st_o[i] = st_q[i];
  end

  assign pend_o     = pend_q;
  assign rsp_fire_o = |rsp_hit;
  assign rsp_st_o   = st_d[rsp_line_i];

endmodule

// File: rtl/mesif_ctrl.sv
module mesif_ctrl
  import mesif_pkg::*;
#(
  parameter  int unsigned NUM_LINES = 8,
  localparam int unsigned LINE_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_op_i,
  input  logic [LINE_W-1:0] req_line_i,
  output logic              req_ready_o,
  output logic              done_valid_o,
  output logic [LINE_W-1:0] done_line_o,
  output logic [2:0]        done_state_o,
  output logic              msg_valid_o,
  output logic [1:0]        msg_type_o,
  output logic [LINE_W-1:0] msg_line_o,
  input  logic              msg_ready_i,
  input  logic              rsp_valid_i,
  input  logic [LINE_W-1:0] rsp_line_i,
  input  logic              rsp_shared_i,
  input  logic              snp_valid_i,
  input  logic              snp_type_i,
  input  logic [LINE_W-1:0] snp_line_i,
  output logic              snp_rsp_valid_o,
  output logic              snp_hit_o,
  output logic              snp_data_o
);

  line_st_e             st      [NUM_LINES];
  logic [NUM_LINES-1:0] pend;
  line_st_e             req_cur, snp_cur, snp_nxt, hit_st, rsp_st;
  msg_type_e            mtype;
  req_op_e              op;
  logic                 need_msg, blocked, fire, rsp_fire;

  assign op      = req_op_e'(req_op_i);
  assign req_cur = st[req_line_i];
  assign snp_cur = st[snp_line_i];

  mesif_req_ctrl u_req (
    .op_i       (op),
    .cur_i      (req_cur),
    .need_msg_o (need_msg),
    .msg_type_o (mtype),
    .hit_st_o   (hit_st)
  );

  mesif_snoop_unit u_snp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .snp_valid_i (snp_valid_i),
    .snp_type_i  (snp_type_i),
    .cur_i       (snp_cur),
    .nxt_o       (snp_nxt),
    .rsp_valid_o (snp_rsp_valid_o),
    .hit_o       (snp_hit_o),
    .data_o      (snp_data_o)
  );

  // snoops and responses own the bank this cycle; one transaction per line
  assign blocked = pend[req_line_i] || rsp_valid_i ||
                   (snp_valid_i && snp_line_i == req_line_i);

  assign req_ready_o = !blocked && (!need_msg || msg_ready_i);
  assign msg_valid_o = req_valid_i && !blocked && need_msg;
  assign msg_type_o  = mtype;
  assign msg_line_o  = req_line_i;
  assign fire        = req_valid_i && req_ready_o;

  mesif_line_bank #(
    .NUM_LINES (NUM_LINES),
    .LINE_W    (LINE_W)
  ) u_bank (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .snp_en_i     (snp_valid_i),
    .snp_line_i   (snp_line_i),
    .snp_st_i     (snp_nxt),
    .req_en_i     (fire),
    .req_line_i   (req_line_i),
    .req_pend_i   (need_msg),
    .req_st_i     (hit_st),
    .req_op_i     (op),
    .rsp_en_i     (rsp_valid_i),
    .rsp_line_i   (rsp_line_i),
    .rsp_shared_i (rsp_shared_i),
    .st_o         (st),
    .pend_o       (pend),
    .rsp_fire_o   (rsp_fire),
    .rsp_st_o     (rsp_st)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_valid_o <= 1'b0;
      done_line_o  <= '0;
      done_state_o <= ST_I;
    end else if (rsp_fire) begin
      done_valid_o <= 1'b1;
      done_line_o  <= rsp_line_i;
      done_state_o <= rsp_st;
    end else if (fire && !need_msg) begin
      done_valid_o <= 1'b1;
      done_line_o  <= req_line_i;
      done_state_o <= hit_st;
    end else begin
      done_valid_o <= 1'b0;
    end
  end

endmodule

// File: rtl/mesif_ctrl_chk.sv
module mesif_ctrl_chk
  import mesif_pkg::*;
#(
  parameter int unsigned LINE_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [1:0]        req_op_i,
  input logic [LINE_W-1:0] req_line_i,
  input logic              req_ready_o,
  input logic              done_valid_o,
  input logic [2:0]        done_state_o,
  input logic              msg_valid_o,
  input logic              rsp_valid_i,
  input logic              snp_valid_i,
  input logic [LINE_W-1:0] snp_line_i,
  input logic              snp_rsp_valid_o,
  input logic              snp_hit_o,
  input logic              snp_data_o
);

  AST_MSG_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> req_valid_i) else $error("message without request"); // R2

  AST_WRITE_SILENT_M: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && req_op_i == OP_WR && !msg_valid_o)
      |=> (done_valid_o && done_state_o == ST_M)) else $error("silent write not M"); // R4

  AST_EVICT_SILENT_I: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && req_op_i == OP_EVICT && !msg_valid_o)
      |=> (done_valid_o && done_state_o == ST_I)) else $error("silent evict not I"); // R6

  AST_RSP_BLOCKS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_i |-> !req_ready_o) else $error("request accepted with response"); // R8

  AST_SNP_RSP_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_valid_i |=> snp_rsp_valid_o) else $error("snoop answer late"); // R9

  AST_DATA_NEEDS_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_data_o |-> (snp_hit_o && snp_rsp_valid_o)) else $error("data without hit"); // R10

  AST_SNOOP_PRIORITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_valid_i && req_valid_i && snp_line_i == req_line_i) |-> !req_ready_o)
    else $error("request beat snoop"); // R11

endmodule

bind mesif_ctrl mesif_ctrl_chk #(.LINE_W(LINE_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_valid_i     (req_valid_i),
  .req_op_i        (req_op_i),
  .req_line_i      (req_line_i),
  .req_ready_o     (req_ready_o),
  .done_valid_o    (done_valid_o),
  .done_state_o    (done_state_o),
  .msg_valid_o     (msg_valid_o),
  .rsp_valid_i     (rsp_valid_i),
  .snp_valid_i     (snp_valid_i),
  .snp_line_i      (snp_line_i),
  .snp_rsp_valid_o (snp_rsp_valid_o),
  .snp_hit_o       (snp_hit_o),
  .snp_data_o      (snp_data_o)
);

// File: tb/mesif_ctrl_tb.sv
module mesif_ctrl_tb;

  localparam int LW = 3;
  localparam int I = 0, S = 1, E = 2, M = 3, F = 4;
  localparam int RD = 0, WR = 1, EV = 2, CL = 3;
  localparam int MRD = 0, MRFO = 1, MWB = 2;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_valid_i = 0, msg_ready_i = 1, rsp_valid_i = 0, rsp_shared_i = 0;
  logic snp_valid_i = 0, snp_type_i = 0;
  logic [1:0] req_op_i = 0;
  logic [LW-1:0] req_line_i = 0, rsp_line_i = 0, snp_line_i = 0;
  logic req_ready_o, done_valid_o, msg_valid_o, snp_rsp_valid_o, snp_hit_o, snp_data_o;
  logic [LW-1:0] done_line_o, msg_line_o;
  logic [2:0] done_state_o;
  logic [1:0] msg_type_o;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  mesif_ctrl #(.NUM_LINES(8)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_op_i(req_op_i), .req_line_i(req_line_i),
    .req_ready_o(req_ready_o),
    .done_valid_o(done_valid_o), .done_line_o(done_line_o), .done_state_o(done_state_o),
    .msg_valid_o(msg_valid_o), .msg_type_o(msg_type_o), .msg_line_o(msg_line_o),
    .msg_ready_i(msg_ready_i),
    .rsp_valid_i(rsp_valid_i), .rsp_line_i(rsp_line_i), .rsp_shared_i(rsp_shared_i),
    .snp_valid_i(snp_valid_i), .snp_type_i(snp_type_i), .snp_line_i(snp_line_i),
    .snp_rsp_valid_o(snp_rsp_valid_o), .snp_hit_o(snp_hit_o), .snp_data_o(snp_data_o)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // core request; exp_msg selects message path or same-cycle-after completion
  task automatic core(int op, int line, int exp_msg, int exp_val, string tag);
    @(negedge clk);
    req_valid_i = 1; req_op_i = 2'(op); req_line_i = LW'(line);
    #1;
    chk({tag, " ready"}, int'(req_ready_o), 1);
    chk({tag, " msg_valid"}, int'(msg_valid_o), exp_msg);
    if (exp_msg != 0) begin
      chk({tag, " msg_type"}, int'(msg_type_o), exp_val);
      chk({tag, " msg_line"}, int'(msg_line_o), line);
    end
    @(posedge clk); #1;
    req_valid_i = 0;
    chk({tag, " done_valid"}, int'(done_valid_o), exp_msg ? 0 : 1);
    if (exp_msg == 0) begin
      chk({tag, " done_state"}, int'(done_state_o), exp_val);
      chk({tag, " done_line"}, int'(done_line_o), line);
    end
  endtask

  task automatic rsp(int line, int shared, int exp_st, string tag);
    @(negedge clk);
    rsp_valid_i = 1; rsp_line_i = LW'(line); rsp_shared_i = shared[0];
    @(posedge clk); #1;
    rsp_valid_i = 0;
    chk({tag, " rsp done_valid"}, int'(done_valid_o), 1);
    chk({tag, " rsp done_state"}, int'(done_state_o), exp_st);
    chk({tag, " rsp done_line"}, int'(done_line_o), line);
  endtask

  task automatic snp(int typ, int line, int exp_hit, int exp_data, string tag);
    @(negedge clk);
    snp_valid_i = 1; snp_type_i = typ[0]; snp_line_i = LW'(line);
    @(posedge clk); #1;
    snp_valid_i = 0;
    chk({tag, " snp valid"}, int'(snp_rsp_valid_o), 1);
    chk({tag, " snp hit"}, int'(snp_hit_o), exp_hit);
    chk({tag, " snp data"}, int'(snp_data_o), exp_data);
  endtask

  task automatic t_reset();
    #1;
    chk("R1 done_valid", int'(done_valid_o), 0);
    chk("R1 snp_rsp_valid", int'(snp_rsp_valid_o), 0);
    chk("R1 msg_valid idle", int'(msg_valid_o), 0);
    chk("R1 ready idle", int'(req_ready_o), 1);
    core(RD, 0, 1, MRD, "R1 read L0 invalid");
  endtask

  task automatic t_read_fill();
    rsp(0, 0, E, "R2 fill unshared");
    core(RD, 1, 1, MRD, "R2 read L1");
    rsp(1, 1, F, "R2 fill shared");
  endtask

  task automatic t_read_hit();
    core(RD, 0, 0, E, "R3 hit E");
    core(RD, 1, 0, F, "R3 hit F");
  endtask

  task automatic t_write_silent();
    core(WR, 0, 0, M, "R4 write E");
    core(WR, 0, 0, M, "R4 write M");
    core(RD, 0, 0, M, "R3 hit M");
  endtask

  task automatic t_rfo();
    core(WR, 1, 1, MRFO, "R5 write F");
    rsp(1, 1, M, "R5 rfo done F");
    core(WR, 2, 1, MRFO, "R5 write I");
    rsp(2, 0, M, "R5 rfo done I");
  endtask

  task automatic t_stall();
    core(WR, 3, 1, MRFO, "R8 write L3");
    @(negedge clk);
    req_valid_i = 1; req_op_i = RD; req_line_i = 3;
    #1;
    chk("R8 pending line ready", int'(req_ready_o), 0);
    chk("R8 pending line msg", int'(msg_valid_o), 0);
    @(posedge clk); #1; req_valid_i = 0;
    chk("R8 pending no done", int'(done_valid_o), 0);
    core(RD, 4, 1, MRD, "R8 other line");
    @(negedge clk);
    rsp_valid_i = 1; rsp_line_i = 3; rsp_shared_i = 0;
    req_valid_i = 1; req_op_i = RD; req_line_i = 5;
    #1;
    chk("R8 rsp blocks ready", int'(req_ready_o), 0);
    @(posedge clk); #1;
    rsp_valid_i = 0; req_valid_i = 0;
    chk("R5 L3 done state", int'(done_state_o), M);
    chk("R8 rsp done line", int'(done_line_o), 3);
    rsp(4, 1, F, "R2 L4 fill");
    core(RD, 5, 1, MRD, "R8 L5 untouched");
    rsp(5, 1, F, "R2 L5 fill");
  endtask

  task automatic t_clean();
    core(CL, 0, 1, MWB, "R7 clean M");
    rsp(0, 0, E, "R7 clean done");
    core(CL, 0, 0, E, "R7 clean E");
  endtask

  task automatic t_evict();
    core(EV, 2, 1, MWB, "R6 evict M");
    rsp(2, 0, I, "R6 evict done");
    core(EV, 4, 0, I, "R6 evict F");
    core(RD, 4, 1, MRD, "R6 read after evict");
    rsp(4, 0, E, "R2 L4 refill");
  endtask

  task automatic t_snoop_read();
    snp(0, 4, 1, 1, "R9 snoop E");
    core(RD, 4, 0, S, "R9 E to S");
    snp(0, 4, 1, 0, "R9 snoop S");
    snp(0, 1, 1, 1, "R9 snoop M");
    core(RD, 1, 0, S, "R9 M to S");
    snp(0, 5, 1, 1, "R9 snoop F");
    core(RD, 5, 0, S, "R9 F to S");
    snp(0, 7, 0, 0, "R9 snoop I");
  endtask

  task automatic t_snoop_inv();
    snp(1, 3, 1, 1, "R10 inv M");
    core(RD, 3, 1, MRD, "R10 after inv M");
    rsp(3, 0, E, "R10 refill");
    snp(1, 3, 1, 0, "R10 inv E");
    snp(1, 2, 0, 0, "R10 inv I");
    core(RD, 3, 1, MRD, "R10 after inv E");
    rsp(3, 1, F, "R10 refill F");
  endtask

  task automatic t_snoop_priority();
    @(negedge clk);
    snp_valid_i = 1; snp_type_i = 0; snp_line_i = 3;
    req_valid_i = 1; req_op_i = RD; req_line_i = 3;
    #1;
    chk("R11 same line ready", int'(req_ready_o), 0);
    @(posedge clk); #1;
    snp_valid_i = 0; req_valid_i = 0;
    chk("R11 snoop F data", int'(snp_data_o), 1);
    chk("R11 no done", int'(done_valid_o), 0);
    core(RD, 3, 0, S, "R11 F now S");
    @(negedge clk);
    snp_valid_i = 1; snp_type_i = 0; snp_line_i = 6;
    req_valid_i = 1; req_op_i = RD; req_line_i = 7;
    #1;
    chk("R11 other line ready", int'(req_ready_o), 1);
    chk("R11 other line msg", int'(msg_valid_o), 1);
    @(posedge clk); #1;
    snp_valid_i = 0; req_valid_i = 0;
    chk("R9 snoop L6 miss", int'(snp_hit_o), 0);
    rsp(7, 0, E, "R11 L7 fill");
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    msg_ready_i = 0;
    req_valid_i = 1; req_op_i = RD; req_line_i = 6;
    #1;
    chk("R8 backpressure ready", int'(req_ready_o), 0);
    chk("R8 backpressure msg", int'(msg_valid_o), 1);
    @(posedge clk); #1;
    req_valid_i = 0;
    chk("R8 backpressure no done", int'(done_valid_o), 0);
    msg_ready_i = 1;
    core(RD, 6, 1, MRD, "R8 after backpressure");
    rsp(6, 0, E, "R8 L6 fill");
  endtask

  task automatic t_clean_race();
    core(CL, 0, 0, E, "R7 clean E again");
    core(WR, 0, 0, M, "R4 write E race");
    core(CL, 0, 1, MWB, "R7 clean race start");
    snp(0, 0, 1, 1, "R9 snoop during wb");
    rsp(0, 0, S, "R7 clean keeps S");
    core(RD, 0, 0, S, "R7 still S");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1;
    t_reset();
    t_read_fill();
    t_read_hit();
    t_write_silent();
    t_rfo();
    t_stall();
    t_clean();
    t_evict();
    t_snoop_read();
    t_snoop_inv();
    t_snoop_priority();
    t_backpressure();
    t_clean_race();
    repeat (3) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule